// File: doc/BRIEF.md
# Powerline Carrier Packet Receiver Decoder

This block rebuilds home-control command packets from a demodulated powerline receive line. It does not sample the line every half cycle of the mains. It times the gap between successive falling edges of the receive signal and infers each bit from that gap and from the bit decoded just before it. A packet opens with a start code of three observed 1 half cycles and a trailing 0, which is assumed rather than seen. Nine data bits follow, each sent as a true/complement pair.

Each data bit yields exactly one falling edge. The gap to the previous edge, counted in half cycles, together with the previous bit, identifies the new bit. The nine bits are then mapped through two fixed inverse tables to a 4-bit house number and a 5-bit key number. The result appears as a one-cycle record pulse with a flags byte. A packet is abandoned when an edge arrives outside every tolerance window. It is also abandoned when the line stays quiet for three mains cycles.

All time values are counted in clock cycles. `HALF_CLKS` is one half mains cycle. The tolerance T is `HALF_CLKS/6`, rounded down. `MIN_GAP_CLKS` is the shortest gap that is still treated as an edge. `SILENCE_CLKS` is the quiet time that aborts a packet.

Top module: `plc_rx_decoder`

## Requirements
- R1: After reset, and until the first packet ends, `rec_valid_o` is low.
- R2: In idle, a falling edge on `rx_i` opens a packet and counts as its first start bit. The second and third edges are each accepted only if their gap d to the previous edge satisfies HALF_CLKS−T < d < HALF_CLKS+T. Any other gap ends the packet silently, with no record, and the block returns to idle.
- R3: While a packet is open, a falling edge whose gap to the last accepted edge is below `MIN_GAP_CLKS` has no effect. Later gaps are still measured from the last accepted edge.
- R4: A data edge with gap d is judged against windows n·HALF_CLKS−T < d < n·HALF_CLKS+T. After a previous 1, n=2 decodes 1 and n=3 decodes 0. After a previous 0, n=1 decodes 1 and n=2 decodes 0. The first data bit is judged as if the previous bit were 1.
- R5: The first decoded data bit becomes bit 8 of a 9-bit code and the ninth becomes bit 0. The ninth data edge completes the packet. A record is then shown for exactly one cycle, with `rec_valid_o` high, at the second clock edge after the edge at which `rx_i` is first sampled low.
- R6: The house number is the table 12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9 indexed by code bits [8:5].
- R7: The key number is the table 12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31 indexed by code bits [4:0].
- R8: `rec_flags_o` bit 0 holds the value of `tx_active_i` sampled with the packet's first edge. Bit 1 marks an error record, and bits 7:2 are 0. An error record always carries house 0 and key 0.
- R9: A data edge whose gap falls in no window of R4 emits an error record at once, with the timing of R5, and returns the block to idle.
- R10: When a packet is open and `SILENCE_CLKS` cycles pass with no accepted edge, the packet is aborted. If only its first edge had been accepted, nothing is emitted. Otherwise an error record appears at the second clock edge after the window expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Demodulated receive line; a falling edge marks a carrier burst |
| tx_active_i | input | 1 | High while the local transmitter is sending |
| rec_valid_o | output | 1 | One-cycle pulse: a record is presented |
| rec_flags_o | output | 8 | Bit 0 local transmit, bit 1 error, others 0 |
| rec_house_o | output | 4 | Decoded house number |
| rec_key_o | output | 5 | Decoded key number |

## Verification
A falling edge on `rx_i` passes through a two-stage synchronizer and one edge register. A completion or data-error record therefore shows on the outputs after the second rising edge that follows the rising edge that first samples the line low. A silence abort shows after the second rising edge that follows the sampling edge at which the gap reaches `SILENCE_CLKS`. The bench reference model samples `rx_i` and `tx_active_i` on each rising edge, using only integer gaps and the stated tables. It schedules each expected record two cycles ahead. At every falling edge it compares `rec_valid_o`, and the record fields whenever a record is due. Per-scenario record counts confirm the silent drops separately.

// File: rtl/plc_rx_pkg.sv
package plc_rx_pkg;
  localparam int unsigned CODE_W  = 9;
  localparam int unsigned HOUSE_W = 4;
  localparam int unsigned KEY_W   = 5;
  localparam int unsigned FLAGS_W = 8;
  localparam int unsigned FLAG_LOCAL = 0;
  localparam int unsigned FLAG_ERR   = 1;
  localparam int unsigned HC_W = 5;

  localparam logic [HC_W-1:0] HC_FIRST       = 5'd1;
  localparam logic [HC_W-1:0] HC_LAST_START  = 5'd2;
  localparam logic [HC_W-1:0] HC_AFTER_START = 5'd4;
  localparam logic [HC_W-1:0] HC_DONE        = 5'd22;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA} phase_e;

  localparam logic [HOUSE_W-1:0] HOUSE_MAP [16] = '{
    4'd12, 4'd4, 4'd2, 4'd10, 4'd14, 4'd6, 4'd0, 4'd8,
    4'd13, 4'd5, 4'd3, 4'd11, 4'd15, 4'd7, 4'd1, 4'd9
  };

  localparam logic [KEY_W-1:0] KEY_MAP [32] = '{
    5'd12, 5'd16, 5'd4,  5'd17, 5'd2,  5'd18, 5'd10, 5'd19,
    5'd14, 5'd20, 5'd6,  5'd21, 5'd0,  5'd22, 5'd8,  5'd23,
    5'd13, 5'd24, 5'd5,  5'd25, 5'd3,  5'd26, 5'd11, 5'd27,
    5'd15, 5'd28, 5'd7,  5'd29, 5'd1,  5'd30, 5'd9,  5'd31
  };

  function automatic logic [HOUSE_W-1:0] house_of(input logic [HOUSE_W-1:0] c);
    return HOUSE_MAP[c];
  endfunction

  function automatic logic [KEY_W-1:0] key_of(input logic [KEY_W-1:0] c);
    return KEY_MAP[c];
  endfunction
endpackage

// File: rtl/plc_rx_sync.sv
module plc_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/plc_rx_gap_timer.sv
module plc_rx_gap_timer #(
  parameter int unsigned LIMIT = 720,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT);

  // gap_o equals the clocks elapsed since the last restart, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_o <= SAT;
    else if (restart_i)   gap_o <= CNT_W'(1);
    else if (gap_o != SAT) gap_o <= gap_o + CNT_W'(1);
  end
endmodule

// File: rtl/plc_rx_frame.sv
module plc_rx_frame
  import plc_rx_pkg::*;
#(
  parameter int unsigned HALF_CLKS    = 120,
  parameter int unsigned MIN_GAP_CLKS = 22,
  parameter int unsigned SILENCE_CLKS = 720,
  parameter int unsigned CNT_W        = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fall_i,
  input  logic               local_i,
  input  logic [CNT_W-1:0]   gap_i,
  output logic               restart_o,
  output logic               busy_o,
  output logic               rec_valid_o,
  output logic [FLAGS_W-1:0] flags_o,
  output logic [HOUSE_W-1:0] house_o,
  output logic [KEY_W-1:0]   key_o
);
  localparam int unsigned TOL = HALF_CLKS / 6;

  function automatic logic near(input int unsigned g, input int unsigned n);
    return ((g + TOL) > (n * HALF_CLKS)) && (g < (n * HALF_CLKS + TOL));
  endfunction

  phase_e            phase_q;
  logic [HC_W-1:0]   hc_q;
  logic [CODE_W-1:0] code_q;
  logic              last_q;
  logic              local_q;

  logic [31:0]       gap_w;
  logic              accept, silent;
  logic              one_ok, two_ok, three_ok;
  logic              bit_one, bit_zero;
  logic [CODE_W-1:0] code_nx;
  logic [HC_W-1:0]   hc_nx;
  logic [FLAGS_W-1:0] flags_ok, flags_err;
  logic              multi_edge;

  assign gap_w    = 32'(gap_i);
  assign accept   = fall_i && ((phase_q == PH_IDLE) || (gap_w >= MIN_GAP_CLKS));
  assign silent   = (phase_q != PH_IDLE) && (gap_w >= SILENCE_CLKS);
  assign one_ok   = near(gap_w, 1);
  assign two_ok   = near(gap_w, 2);
  assign three_ok = near(gap_w, 3);
  assign bit_one  = last_q ? two_ok   : one_ok;
  assign bit_zero = last_q ? three_ok : two_ok;
  assign code_nx  = {code_q[CODE_W-2:0], bit_one};
  assign hc_nx    = hc_q + HC_W'(2);
  assign multi_edge = (phase_q == PH_DATA) || (hc_q >= HC_LAST_START);

  always_comb begin
    flags_ok  = '0;
    flags_err = '0;
    flags_ok[FLAG_LOCAL]  = local_q;
    flags_err[FLAG_LOCAL] = local_q;
    flags_err[FLAG_ERR]   = 1'b1;
  end

  assign restart_o = accept;
  assign busy_o    = (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      hc_q        <= '0;
      code_q      <= '0;
      last_q      <= 1'b0;
      local_q     <= 1'b0;
      rec_valid_o <= 1'b0;
      flags_o     <= '0;
      house_o     <= '0;
      key_o       <= '0;
    end else begin
      rec_valid_o <= 1'b0;
      if (accept) begin
        unique case (phase_q)
          PH_IDLE: begin
            phase_q <= PH_START;
            hc_q    <= HC_FIRST;
            code_q  <= '0;
            last_q  <= 1'b1;
            local_q <= local_i;
          end
          PH_START: begin
            if (one_ok) begin
              if (hc_q == HC_LAST_START) begin
                hc_q    <= HC_AFTER_START;  // trailing 0 assumed
                phase_q <= PH_DATA;
              end else begin
                hc_q <= hc_q + HC_W'(1);
              end
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_DATA: begin
            if (bit_one || bit_zero) begin
              code_q <= code_nx;
              last_q <= bit_one;
              hc_q   <= hc_nx;
              if (hc_nx == HC_DONE) begin
                rec_valid_o <= 1'b1;
                flags_o     <= flags_ok;
                house_o     <= house_of(code_nx[CODE_W-1 -: HOUSE_W]);
                key_o       <= key_of(code_nx[KEY_W-1:0]);
                phase_q     <= PH_IDLE;
              end
            end else begin
              rec_valid_o <= 1'b1;
              flags_o     <= flags_err;
              house_o     <= '0;
              key_o       <= '0;
              phase_q     <= PH_IDLE;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end else if (silent) begin
        phase_q <= PH_IDLE;
        if (multi_edge) begin
          rec_valid_o <= 1'b1;
          flags_o     <= flags_err;
          house_o     <= '0;
          key_o       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/plc_rx_decoder.sv
module plc_rx_decoder
  import plc_rx_pkg::*;
#(
  parameter int unsigned HALF_CLKS    = 120,
  parameter int unsigned MIN_GAP_CLKS = 22,
  parameter int unsigned SILENCE_CLKS = 720,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  input  logic               tx_active_i,
  output logic               rec_valid_o,
  output logic [FLAGS_W-1:0] rec_flags_o,
  output logic [HOUSE_W-1:0] rec_house_o,
  output logic [KEY_W-1:0]   rec_key_o
);
  localparam int unsigned CNT_W   = $clog2(SILENCE_CLKS + 1);
  localparam int unsigned N_SYNC  = 2;
  localparam logic [N_SYNC-1:0] SYNC_RST = 2'b01;  // rx idles high

  logic [N_SYNC-1:0] raw_in, synced;
  logic              rx_prev_q;
  logic              fall, restart, busy;
  logic [CNT_W-1:0]  gap;

  assign raw_in = {tx_active_i, rx_i};

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    plc_rx_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST[i])
    ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in[i]),
      .q_o    (synced[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_prev_q <= 1'b1;
    else         rx_prev_q <= synced[0];
  end

  assign fall = rx_prev_q & ~synced[0];

  plc_rx_gap_timer #(
    .LIMIT (SILENCE_CLKS),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .gap_o     (gap)
  );

  plc_rx_frame #(
    .HALF_CLKS    (HALF_CLKS),
    .MIN_GAP_CLKS (MIN_GAP_CLKS),
    .SILENCE_CLKS (SILENCE_CLKS),
    .CNT_W        (CNT_W)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .local_i     (synced[1]),
    .gap_i       (gap),
    .restart_o   (restart),
    .busy_o      (busy),
    .rec_valid_o (rec_valid_o),
    .flags_o     (rec_flags_o),
    .house_o     (rec_house_o),
    .key_o       (rec_key_o)
  );
endmodule

// File: rtl/plc_rx_decoder_chk.sv
module plc_rx_decoder_chk #(
  parameter int unsigned MIN_GAP_CLKS = 22,
  parameter int unsigned SILENCE_CLKS = 720,
  parameter int unsigned CNT_W        = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_o,
  input logic [7:0]       rec_flags_o,
  input logic [3:0]       rec_house_o,
  input logic [4:0]       rec_key_o,
  input logic             fall_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] gap_i
);
  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  assert_idle_after_rec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !busy_i);

  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_flags_o[1]) |-> (rec_house_o == 4'd0 && rec_key_o == 5'd0));

  assert_flags_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_flags_o[7:2] == 6'd0));

  assert_short_gap_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && fall_i && (32'(gap_i) < MIN_GAP_CLKS))
      |=> (gap_i == CNT_W'($past(gap_i) + 1'b1)));

  assert_silence_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (32'(gap_i) >= SILENCE_CLKS)) |=> !busy_i);
endmodule

bind plc_rx_decoder plc_rx_decoder_chk #(
  .MIN_GAP_CLKS (MIN_GAP_CLKS),
  .SILENCE_CLKS (SILENCE_CLKS),
  .CNT_W        (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rec_valid_o (rec_valid_o),
  .rec_flags_o (rec_flags_o),
  .rec_house_o (rec_house_o),
  .rec_key_o   (rec_key_o),
  .fall_i      (fall),
  .busy_i      (busy),
  .gap_i       (gap)
);

// File: tb/plc_rx_decoder_bench.sv
module plc_rx_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 120;
  localparam int TOL = H / 6;
  localparam int MIN_GAP = 22;
  localparam int SIL = 720;

  logic clk = 1'b0;
  logic rst_n;
  logic rx, tx_act;
  logic valid;
  logic [7:0] flags;
  logic [3:0] house;
  logic [4:0] key;

  always #(CLK_PERIOD/2) clk = ~clk;

  plc_rx_decoder #(
    .HALF_CLKS(H), .MIN_GAP_CLKS(MIN_GAP), .SILENCE_CLKS(SIL), .SYNC_STAGES(2)
  ) u_plc_rx_decoder (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_active_i(tx_act),
    .rec_valid_o(valid), .rec_flags_o(flags), .rec_house_o(house), .rec_key_o(key)
  );

  int house_tbl [16] = '{12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9};
  int key_tbl [32] = '{12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,
                       13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31};

  int n_chk = 0, n_fail = 0, n_rec = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int cyc = 0;
  bit m_prev = 1;
  int m_state = 0, m_hc = 0, m_last = 1, m_local = 0, m_code = 0, m_lastacc = 0;
  int q_at[$], q_fl[$], q_h[$], q_k[$];

  function automatic bit win(int d, int n);
    return (d > n*H - TOL) && (d < n*H + TOL);
  endfunction

  task automatic push_rec(int fl, int h, int k);
    q_at.push_back(cyc + 2); q_fl.push_back(fl); q_h.push_back(h); q_k.push_back(k);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_prev = 1; m_state = 0;
    end else begin
      bit f;
      int d;
      int b;
      cyc++;
      f = m_prev && !rx;
      m_prev = rx;
      d = cyc - m_lastacc;
      if (f && (m_state == 0 || d >= MIN_GAP)) begin
        if (m_state == 0) begin
          m_state = 1; m_hc = 1; m_last = 1; m_code = 0; m_local = tx_act;
        end else if (m_state == 1) begin
          if (win(d, 1)) begin
            m_hc++;
            if (m_hc == 3) begin m_hc = 4; m_state = 2; end
          end else m_state = 0;
        end else begin
          b = -1;
          if (m_last == 1) begin
            if (win(d, 2)) b = 1; else if (win(d, 3)) b = 0;
          end else begin
            if (win(d, 1)) b = 1; else if (win(d, 2)) b = 0;
          end
          if (b < 0) begin
            push_rec(2 | m_local, 0, 0); m_state = 0;
          end else begin
            m_code = ((m_code << 1) | b) & 511;
            m_last = b; m_hc += 2;
            if (m_hc == 22) begin
              push_rec(m_local, house_tbl[m_code >> 5], key_tbl[m_code & 31]);
              m_state = 0;
            end
          end
        end
        m_lastacc = cyc;
      end else if (m_state != 0 && d >= SIL) begin
        if (m_state == 2 || m_hc >= 2) push_rec(2 | m_local, 0, 0);
        m_state = 0;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      if (q_at.size() > 0 && q_at[0] < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: record missing at cycle %0d, actual none expected flags=%0h", cur_req, q_at[0], q_fl[0]);
        void'(q_at.pop_front()); void'(q_fl.pop_front()); void'(q_h.pop_front()); void'(q_k.pop_front());
      end
      ev = (q_at.size() > 0) && (q_at[0] == cyc);
      if (valid) n_rec++;
      if (ev || valid) begin
        n_chk++;
        if (valid !== ev) begin
          n_fail++;
          $display("FAIL %s R5: valid actual %0b expected %0b at cycle %0d", cur_req, valid, ev, cyc);
        end else if (flags !== 8'(q_fl[0]) || house !== 4'(q_h[0]) || key !== 5'(q_k[0])) begin
          n_fail++;
          $display("FAIL %s R6 R7 R8: actual flags=%0h house=%0d key=%0d expected flags=%0h house=%0d key=%0d",
                   cur_req, flags, house, key, q_fl[0], q_h[0], q_k[0]);
        end
        if (ev) begin
          void'(q_at.pop_front()); void'(q_fl.pop_front()); void'(q_h.pop_front()); void'(q_k.pop_front());
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic scn(string req);
    cur_req = req; n_rec = 0;
  endtask

  task automatic do_fall(int gap);
    repeat (gap - 3) @(negedge clk);
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
  endtask

  function automatic int raw_house(int h);
    for (int r = 0; r < 16; r++) if (house_tbl[r] == h) return r;
    return 0;
  endfunction

  function automatic int raw_key(int k);
    for (int r = 0; r < 32; r++) if (key_tbl[r] == k) return r;
    return 0;
  endfunction

  task automatic send_packet(int h, int k, int jit, int sj, bit glitch);
    int code, pos, np, g, b;
    code = (raw_house(h) << 5) | raw_key(k);
    do_fall(4);
    do_fall(H + sj);
    do_fall(H + sj);
    pos = 2;
    for (int i = 0; i < 9; i++) begin
      b = (code >> (8 - i)) & 1;
      np = 4 + 2*i + ((b == 1) ? 0 : 1);
      g = (np - pos) * H + (((i % 2) == 1) ? -jit : jit);
      if (glitch && i == 0) begin
        do_fall(10);
        do_fall(g - 10);
      end else begin
        do_fall(g);
      end
      pos = np;
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rx = 1'b1; tx_act = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(valid), 0);
    repeat (10) @(negedge clk);
    chk("R1 valid while idle", int'(valid), 0);

    scn("R4 R5 R6 R7");
    send_packet(0, 0, 0, 0, 0);
    chk("R5 one record", n_rec, 1);

    scn("R6 R7 house sweep");
    for (int i = 0; i < 16; i++) send_packet(i, (i*5 + 3) % 16, 0, 0, 0);
    chk("R6 house sweep records", n_rec, 16);

    scn("R7 key sweep");
    for (int k = 16; k < 32; k++) send_packet((k*7) % 16, k, 0, 0, 0);
    chk("R7 key sweep records", n_rec, 16);

    scn("R8 local flag");
    tx_act = 1'b1;
    send_packet(5, 17, 0, 0, 0);
    tx_act = 1'b0;
    chk("R8 local record", n_rec, 1);

    scn("R4 jitter inside window");
    send_packet(9, 22, TOL - 1, -(TOL - 1), 0);
    send_packet(3, 31, -(TOL - 1), TOL - 1, 0);
    chk("R4 jitter records", n_rec, 2);

    scn("R3 short glitch");
    send_packet(14, 8, 0, 0, 1);
    chk("R3 glitch ignored", n_rec, 1);

    scn("R2 start late edge");
    do_fall(4); do_fall(H + TOL);
    repeat (SIL + 30) @(negedge clk);
    chk("R2 late start no record", n_rec, 0);

    scn("R2 start early edge");
    do_fall(4); do_fall(H - TOL);
    repeat (SIL + 30) @(negedge clk);
    chk("R2 early start no record", n_rec, 0);

    scn("R2 start edge just inside");
    send_packet(7, 2, 0, TOL - 1, 0);
    chk("R2 inside start record", n_rec, 1);

    scn("R9 bad data gap");
    do_fall(4); do_fall(H); do_fall(H); do_fall(300);
    repeat (20) @(negedge clk);
    chk("R9 error record", n_rec, 1);
    tx_act = 1'b1;
    do_fall(4); do_fall(H); do_fall(H); do_fall(2*H); do_fall(H + 60);
    repeat (20) @(negedge clk);
    tx_act = 1'b0;
    chk("R9 error record local", n_rec, 2);

    scn("R10 silence after one edge");
    do_fall(4);
    repeat (SIL + 30) @(negedge clk);
    chk("R10 silent abort", n_rec, 0);

    scn("R10 silence after two edges");
    do_fall(4); do_fall(H);
    repeat (SIL + 30) @(negedge clk);
    chk("R10 error after two edges", n_rec, 1);

    scn("R10 silence mid data");
    do_fall(4); do_fall(H); do_fall(H); do_fall(2*H); do_fall(2*H);
    repeat (SIL + 30) @(negedge clk);
    chk("R10 error mid data", n_rec, 1);

    repeat (50) @(negedge clk);
    chk("R5 all expected records seen", q_at.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule